// File: doc/BRIEF.md
# Serial SRAM Target

This block is a byte-addressed serial memory that answers on an SPI bus as a target device. A host lowers chip select, sends a one-byte command and a 16-bit address, and then moves data bytes in or out at consecutive addresses until it raises chip select again. Three commands are recognised: a plain read, which returns data with no gap after the address; a fast read, which places one dummy byte between the address and the data; and a write. Any other command byte makes the block ignore the rest of the transaction.

The bus pins are brought into a fast system clock through two-flop synchronisers. Serial clock edges are found in that domain. Inputs are sampled on the detected rising edge. The data output changes only after a detected falling edge, so it is stable when the host samples on the next rising edge. SPI modes 0 and 3 are both served. The storage holds `2**MEM_AW` bytes and is indexed by the low `MEM_AW` bits of the received address. A full 64 KiB array takes `MEM_AW = 16`, and the default is smaller so the design elaborates quickly.

Top module: `spi_sram_target`

## Requirements
- R1: Command bytes arrive MSB first and are sampled on SCK rising edges; 0x03 selects plain read, 0x0B fast read and 0x02 write.
- R2: The 16-bit address follows the command MSB first; the storage location is the address modulo `2**MEM_AW` (with `MEM_AW = 10`, address 0x0405 reaches the same byte as 0x0005).
- R3: After a write command and address, each complete received byte is stored, the first at the given address and each next one at the following address.
- R4: On a plain read, the MSB of the addressed byte appears on MISO after the SCK falling edge that directly follows the last address bit, with no dummy clocks, and bytes go out MSB first.
- R5: On a fast read, the eight SCK clocks after the address carry no data and the MOSI value during them is ignored; the data phase then behaves as in R4.
- R6: A read continues through successive addresses for as many bytes as the host clocks, with no gap between bytes.
- R7: Raising CS ends any transaction; a write byte with fewer than eight bits received is discarded, and the next transaction starts with a command byte.
- R8: A command byte other than 0x03, 0x0B or 0x02 leaves memory unchanged and keeps MISO low until CS rises.
- R9: MISO is low while CS is high and changes only in the cycle after a detected SCK falling edge or while CS is high.
- R10: Operation is correct in SPI mode 0 and mode 3 with an SCK period of six system clocks or longer.
- R11: After reset MISO is low and the block waits for a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least six times the SCK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, low when not selected |

## Verification
The assertions assume that each SCK half period lasts at least three system clocks, so a detected rising edge is never followed by a detected falling edge in the next cycle. They also assume that MOSI and CS change only while SCK is low or idle. The bench keeps to this by holding every SCK level for three or more system clocks. It changes MOSI together with the falling edge and moves CS only with SCK idle, a half period away from any edge. All stimulus is applied on the system clock's falling edge, so synchroniser sampling never sees a changing input.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

  localparam int ADDR_BITS = 16;
  localparam int BYTE_BITS = 8;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_FAST  = 8'h0B;
  localparam logic [7:0] OPC_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_READ,
    PH_WRITE,
    PH_SKIP
  } phase_e;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_READ,
    KIND_FAST,
    KIND_WRITE
  } kind_e;

  // Map a command byte to the kind of transaction it opens.
  function automatic kind_e decode_cmd(input logic [7:0] op);
    case (op)
      OPC_READ:  return KIND_READ;
      OPC_FAST:  return KIND_FAST;
      OPC_WRITE: return KIND_WRITE;
      default:   return KIND_NONE;
    endcase
  endfunction

  // Sequential addressing: next byte location.
  function automatic logic [ADDR_BITS-1:0] next_loc(input logic [ADDR_BITS-1:0] a);
    return a + {{(ADDR_BITS-1){1'b0}}, 1'b1};
  endfunction

  // Phase that follows a complete address for a given transaction kind.
  function automatic phase_e after_addr(input kind_e k);
    case (k)
      KIND_READ:  return PH_READ;
      KIND_FAST:  return PH_DUMMY;
      KIND_WRITE: return PH_WRITE;
      default:    return PH_SKIP;
    endcase
  endfunction

endpackage

// File: rtl/spi_sram_sync.sv
module spi_sram_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_high,
  output logic mosi_s
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] mosi_q;
  logic              sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[STAGES-2:0], sck};
      cs_q   <= {cs_q[STAGES-2:0], cs_n};
      mosi_q <= {mosi_q[STAGES-2:0], mosi};
      sck_d  <= sck_q[LAST];
    end
  end

  assign sck_rise = sck_q[LAST] & ~sck_d;
  assign sck_fall = ~sck_q[LAST] & sck_d;
  assign cs_high  = cs_q[LAST];
  assign mosi_s   = mosi_q[LAST];

endmodule

// File: rtl/spi_sram_mem.sv
module spi_sram_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    if (re) rdata <= store[addr];
  end

endmodule

// File: rtl/spi_sram_engine.sv
module spi_sram_engine
  import spi_sram_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck_rise,
  input  logic                 sck_fall,
  input  logic                 cs_high,
  input  logic                 mosi_s,
  input  logic [7:0]           rd_data,
  output logic                 rd_req,
  output logic                 wr_req,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic [7:0]           wr_data,
  output logic                 miso,
  output phase_e               phase
);

  localparam int CNT_W = $clog2(ADDR_BITS);

  kind_e                kind;
  logic [CNT_W-1:0]     bit_cnt;
  logic [ADDR_BITS-1:0] rx_sh;
  logic [ADDR_BITS-1:0] rx_next;
  logic [ADDR_BITS-1:0] loc;
  logic [7:0]           tx_sh;
  logic                 load_pend;
  logic                 miso_q;
  logic                 byte_end;
  logic                 addr_end;
  kind_e                cmd_kind;

  assign rx_next  = {rx_sh[ADDR_BITS-2:0], mosi_s};
  assign byte_end = (bit_cnt[2:0] == 3'd7);
  assign addr_end = (bit_cnt == CNT_W'(ADDR_BITS - 1));
  assign cmd_kind = decode_cmd(rx_next[7:0]);
  assign wr_data  = rx_next[7:0];
  assign miso     = miso_q;

  // Memory requests are issued in the cycle the completing rising edge is seen.
  always_comb begin
    rd_req   = 1'b0;
    wr_req   = 1'b0;
    mem_addr = loc;
    if (sck_rise && !cs_high) begin
      case (phase)
        PH_ADDR: if (addr_end && kind == KIND_READ) begin
          rd_req   = 1'b1;
          mem_addr = rx_next;
        end
        PH_DUMMY: if (byte_end) rd_req = 1'b1;
        PH_READ: if (byte_end) begin
          rd_req   = 1'b1;
          mem_addr = next_loc(loc);
        end
        PH_WRITE: if (byte_end) wr_req = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      kind      <= KIND_NONE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      loc       <= '0;
      tx_sh     <= '0;
      load_pend <= 1'b0;
      miso_q    <= 1'b0;
    end else if (cs_high) begin
      phase     <= PH_CMD;
      kind      <= KIND_NONE;
      bit_cnt   <= '0;
      load_pend <= 1'b0;
      miso_q    <= 1'b0;
    end else begin
      load_pend <= rd_req;
      if (sck_rise) begin
        rx_sh   <= rx_next;
        bit_cnt <= bit_cnt + CNT_W'(1);
        case (phase)
          PH_CMD: if (byte_end) begin
            bit_cnt <= '0;
            kind    <= cmd_kind;
            phase   <= (cmd_kind == KIND_NONE) ? PH_SKIP : PH_ADDR;
          end
          PH_ADDR: if (addr_end) begin
            bit_cnt <= '0;
            loc     <= rx_next;
            phase   <= after_addr(kind);
          end
          PH_DUMMY: if (byte_end) begin
            bit_cnt <= '0;
            phase   <= PH_READ;
          end
          PH_READ, PH_WRITE: if (byte_end) begin
            bit_cnt <= '0;
            loc     <= next_loc(loc);
          end
          default: bit_cnt <= '0;
        endcase
      end
      if (sck_fall && phase == PH_READ) begin
        miso_q <= tx_sh[7];
        tx_sh  <= {tx_sh[6:0], 1'b0};
      end
      if (load_pend) tx_sh <= rd_data;
    end
  end

endmodule

// File: rtl/spi_sram_target.sv
module spi_sram_target
  import spi_sram_pkg::*;
#(
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);

  logic                 sck_rise;
  logic                 sck_fall;
  logic                 cs_high;
  logic                 mosi_s;
  logic                 rd_req;
  logic                 wr_req;
  logic [ADDR_BITS-1:0] mem_addr;
  logic [7:0]           wr_data;
  logic [7:0]           rd_data;
  phase_e               phase;

  // Named events for the checker.
  logic ph_cmd;
  logic ph_write;
  logic ph_skip;
  assign ph_cmd   = (phase == PH_CMD);
  assign ph_write = (phase == PH_WRITE);
  assign ph_skip  = (phase == PH_SKIP);

  spi_sram_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_high  (cs_high),
    .mosi_s   (mosi_s)
  );

  spi_sram_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_high  (cs_high),
    .mosi_s   (mosi_s),
    .rd_data  (rd_data),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .mem_addr (mem_addr),
    .wr_data  (wr_data),
    .miso     (miso),
    .phase    (phase)
  );

  spi_sram_mem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk   (clk),
    .we    (wr_req),
    .re    (rd_req),
    .addr  (mem_addr[MEM_AW-1:0]),
    .wdata (wr_data),
    .rdata (rd_data)
  );

  generate
    if (MEM_AW < ADDR_BITS) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^mem_addr[ADDR_BITS-1:MEM_AW];
    end
  endgenerate

endmodule

// File: rtl/spi_sram_chk.sv
module spi_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_high,
  input logic sck_rise,
  input logic sck_fall,
  input logic rd_req,
  input logic wr_req,
  input logic ph_cmd,
  input logic ph_write,
  input logic ph_skip,
  input logic miso
);

  // R9
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_high && $past(cs_high)) |-> !miso);

  // R9
  miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(sck_fall) || $past(cs_high)));

  // R3
  wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (ph_write && !rd_req));

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> ph_cmd);

  // R8
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_skip |-> (!wr_req && !rd_req));

  // R10
  sck_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !sck_fall);

  // R4
  rd_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (sck_rise && !cs_high));

endmodule

bind spi_sram_target spi_sram_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_high  (cs_high),
  .sck_rise (sck_rise),
  .sck_fall (sck_fall),
  .rd_req   (rd_req),
  .wr_req   (wr_req),
  .ph_cmd   (ph_cmd),
  .ph_write (ph_write),
  .ph_skip  (ph_skip),
  .miso     (miso)
);

// File: tb/tb_spi_sram_target.sv
`timescale 1ns/1ps
module tb_spi_sram_target;

  localparam int MEM_AW = 10;
  localparam int MASK   = (1 << MEM_AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  always #2 clk = ~clk;

  spi_sram_target #(.MEM_AW(MEM_AW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] tx_buf [0:63];
  logic [7:0] rx_buf [0:63];
  logic [7:0] shadow [0:MASK];

  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      logic [7:0] g;
      logic [7:0] e;
      string t;
      wait (got_q.size() != 0);
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, g, e);
    end
  end

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 37 + seed * 11) ^ (a >> 2));
  endfunction

  task automatic run_txn(input int nbytes, input int tail_bits, input int half, input bit mode3);
    sck = mode3;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (half) @(negedge clk);
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] r;
      for (int i = 7; i >= 0; i--) begin
        sck  = 1'b0;
        mosi = tx_buf[b][i];
        repeat (half) @(negedge clk);
        r[i] = miso;
        sck = 1'b1;
        repeat (half) @(negedge clk);
      end
      rx_buf[b] = r;
    end
    for (int i = 7; i > 7 - tail_bits; i--) begin
      sck  = 1'b0;
      mosi = tx_buf[nbytes][i];
      repeat (half) @(negedge clk);
      sck = 1'b1;
      repeat (half) @(negedge clk);
    end
    if (!mode3) sck = 1'b0;
    repeat (half) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_write(input int addr, input int n, input int seed, input int tail,
                          input int half, input bit mode3);
    tx_buf[0] = 8'h02;
    tx_buf[1] = 8'(addr >> 8);
    tx_buf[2] = 8'(addr);
    for (int i = 0; i < n; i++) begin
      tx_buf[3 + i] = pat(addr + i, seed);
      shadow[(addr + i) & MASK] = pat(addr + i, seed);
    end
    tx_buf[3 + n] = 8'hC3;
    run_txn(3 + n, tail, half, mode3);
  endtask

  task automatic do_read(input logic [7:0] op, input int addr, input int n, input int half,
                         input bit mode3, input string tag);
    int off;
    off = (op == 8'h0B) ? 4 : 3;
    tx_buf[0] = op;
    tx_buf[1] = 8'(addr >> 8);
    tx_buf[2] = 8'(addr);
    tx_buf[3] = 8'hA5;
    for (int i = 0; i < n; i++) begin
      tx_buf[off + i] = 8'h5A;
      exp_q.push_back(shadow[(addr + i) & MASK]);
      tag_q.push_back(tag);
    end
    run_txn(off + n, 0, half, mode3);
    for (int i = 0; i < n; i++) got_q.push_back(rx_buf[off + i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 miso in reset", {7'd0, miso}, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 miso after reset", {7'd0, miso}, 8'h00);

    // R3 write, then R1/R4/R6 plain read back, mode 0 at the fastest rate
    do_write(16'h0010, 8, 1, 0, 3, 1'b0);
    do_read(8'h03, 16'h0010, 8, 3, 1'b0, "R4 plain read");

    // R5 fast read from a middle address
    do_read(8'h0B, 16'h0012, 4, 3, 1'b0, "R5 fast read");

    // R10 mode 3, and a slower clock
    do_read(8'h03, 16'h0013, 3, 3, 1'b1, "R10 mode3 read");
    do_write(16'h0080, 4, 2, 0, 3, 1'b1);
    do_read(8'h03, 16'h0080, 4, 6, 1'b0, "R10 slow read");
    do_read(8'h0B, 16'h0081, 3, 3, 1'b1, "R10 mode3 fast");

    // R8 unknown command: looks like a write, must change nothing, MISO low
    tx_buf[0] = 8'h05; tx_buf[1] = 8'h00; tx_buf[2] = 8'h10;
    for (int i = 3; i < 8; i++) tx_buf[i] = 8'hEE;
    run_txn(8, 0, 3, 1'b0);
    for (int i = 3; i < 8; i++) check("R8 miso low", rx_buf[i], 8'h00);
    do_read(8'h03, 16'h0010, 4, 3, 1'b0, "R8 unchanged");

    // R9 MISO low with CS high
    for (int i = 0; i < 4; i++) begin
      check("R9 idle miso", {7'd0, miso}, 8'h00);
      repeat (3) @(negedge clk);
    end

    // R7 abort in the middle of a write byte
    do_write(16'h0040, 3, 3, 0, 3, 1'b0);
    do_write(16'h0040, 2, 4, 4, 3, 1'b0);
    do_read(8'h03, 16'h0040, 3, 3, 1'b0, "R7 partial byte dropped");

    // R2 address aliasing onto the low bits
    do_write(16'h0405, 1, 5, 0, 3, 1'b0);
    do_read(8'h03, 16'h0005, 1, 3, 1'b0, "R2 alias");

    // R6 long stream
    do_write(16'h0200, 40, 6, 0, 3, 1'b0);
    do_read(8'h03, 16'h0200, 40, 3, 1'b1, "R6 long read");
    do_read(8'h0B, 16'h0207, 20, 4, 1'b0, "R6 long fast read");

    wait (got_q.size() == 0);
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule